// File: doc/BRIEF.md
# Prioritised Auto-Acknowledging Interrupt Controller

This block gathers a parameterised set of level-sensitive interrupt sources (64 by default) and presents them to a small group of processors (2 by default). A source is pending when its input line is high or software has raised its trigger bit. It takes part in delivery only while its mask bit is clear. Each source carries a routing bitmask that selects which processors may receive it. Every processor sees a request output that stays high while it has at least one deliverable source.

Software reaches the block through a simple word-addressed bus with valid/ready handshake and a processor-index field. Reading the banked event word returns the lowest-numbered deliverable source for the accessing processor. The same read acknowledges that source by setting its mask bit, so the handler re-enables it later by writing the mask-clear word. Mask and trigger state are each changed through separate set and clear words. A write bit of 1 acts on its source and a write bit of 0 leaves it alone, so no read-modify-write is needed.

Top module: `prio_irq_ctrl`

## Requirements
- R1: A source is deliverable to processor c when (line OR trigger bit) is 1, its mask bit is 0 and bit c of its routing mask is 1; `cpu_irq[c]` is high exactly while some source is deliverable to c, following the register state with no extra cycle.
- R2: Among deliverable sources, the event word reports the one with the smallest number.
- R3: A non-empty event word has bits [31:24] = 0, bits [23:16] = 1 (hardware source type) and bits [15:0] = the source number.
- R4: A read of the event word (word address 0x001) sets the mask bit of the source it returns at the same clock edge, so a second read returns the next source.
- R5: When nothing is deliverable to the reading processor, the event word reads as 0 and no mask bit changes.
- R6: Word addresses 0x010+w (mask set), 0x020+w (mask clear), 0x030+w (trigger set) and 0x040+w (trigger clear) act on sources 32w..32w+31, bit b of the data addressing source 32w+b; 1 bits act and 0 bits have no effect. A read of any of these four addresses returns the current 32 mask or trigger bits of that word.
- R7: After reset all mask bits are 1, all trigger bits are 0, every routing mask is 1 (processor 0) and `cpu_irq` is all zero.
- R8: Word address 0x100+n holds the routing mask of source n (bit c = processor c), read and written whole; the event word of processor c ignores sources whose bit c is 0.
- R9: A read of word address 0x000 returns the index of the processor making the access.
- R10: `bus_ready` is always high; an accepted read returns its data with `bus_rvalid` high on the next cycle, and `bus_rvalid` is low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| irq_in | input | N_SRC | Level-sensitive source lines |
| bus_valid | input | 1 | Access request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_cpu | input | CPU_W | Index of the accessing processor |
| bus_addr | input | 10 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_ready | output | 1 | Access accepted |
| bus_rvalid | output | 1 | Read data valid |
| bus_rdata | output | 32 | Read data |
| cpu_irq | output | N_CPU | Per-processor request |

## Verification
Directed sequences first confirm the reset image, then raise one line under its mask, then combine a software trigger with two lines in different mask words so that successive event reads must come out as 3, 5, 40 and then zero. That ordering separates priority, auto-masking and the trigger OR. A routing change sends one source to processor 1 only, which tells the banked view apart from a shared one. A seeded random phase then mixes sparse line patterns, set and clear writes with random bit densities, routing masks with zero, one or both processor bits, and event reads from either processor. It compares every read and both request outputs against a bench model, which exposes wrong word or bit indexing, writes of 0 bits that leak, and acknowledges charged to the wrong processor.

// File: rtl/prio_irq_pkg.sv
// Package: address map and event word layout shared by the controller.
package prio_irq_pkg;

    // Word address width of the register port.
    localparam int ADDR_W = 10;

    // Region select in address bits [9:8].
    localparam logic [1:0] REGION_LOW    = 2'b00;
    localparam logic [1:0] REGION_ROUTE  = 2'b01;

    // Group select in address bits [7:4] within the low region.
    localparam logic [3:0] GRP_CTRL      = 4'h0;
    localparam logic [3:0] GRP_MASK_SET  = 4'h1;
    localparam logic [3:0] GRP_MASK_CLR  = 4'h2;
    localparam logic [3:0] GRP_TRIG_SET  = 4'h3;
    localparam logic [3:0] GRP_TRIG_CLR  = 4'h4;

    // Offsets inside the control group.
    localparam logic [3:0] OFS_WHOAMI    = 4'h0;
    localparam logic [3:0] OFS_EVENT     = 4'h1;

    // Event type code for a hardware source.
    localparam logic [7:0] EV_TYPE_HW    = 8'd1;

    // Build an event word for a hardware source number.
    function automatic logic [31:0] make_event(input logic [15:0] num);
        return {8'h00, EV_TYPE_HW, num};
    endfunction

endpackage

// File: rtl/pic_bitvec_bank.sv
// Module: pic_bitvec_bank
// Holds one state bit per source, changed through word-wide set and clear
// strobes (bit b of the data acts on source 32*word+b) plus a per-source
// automatic set input. Clear wins over both kinds of set.
// Assumes: word_idx already range-checked by the caller.
module pic_bitvec_bank #(
    parameter int   N_SRC     = 64,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_we,
    input  logic             clr_we,
    input  logic [3:0]       word_idx,
    input  logic [31:0]      wdata,
    input  logic [N_SRC-1:0] auto_set,
    output logic [N_SRC-1:0] state
);

    logic [N_SRC-1:0] set_vec;
    logic [N_SRC-1:0] clr_vec;

    // Expand the word write into per-source set and clear strobes.
    always_comb begin
        for (int i = 0; i < N_SRC; i++) begin
            set_vec[i] = set_we && ((i / 32) == int'(word_idx)) && wdata[i % 32];
            clr_vec[i] = clr_we && ((i / 32) == int'(word_idx)) && wdata[i % 32];
        end
    end

    // State update: set sources OR in, clear has the last word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= {N_SRC{RESET_VAL}};
        end else begin
            state <= (state | set_vec | auto_set) & ~clr_vec;
        end
    end

endmodule

// File: rtl/pic_route_bank.sv
// Module: pic_route_bank
// One routing mask per source, one bit per processor, written whole.
// Assumes: src_idx below N_SRC whenever we is high.
module pic_route_bank #(
    parameter int N_SRC = 64,
    parameter int N_CPU = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        we,
    input  logic [7:0]                  src_idx,
    input  logic [N_CPU-1:0]            wmask,
    output logic [N_SRC-1:0][N_CPU-1:0] route
);

    for (genvar s = 0; s < N_SRC; s++) begin : g_src
        // Routing register of source s, processor 0 after reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                route[s] <= N_CPU'(1);
            end else if (we && (int'(src_idx) == s)) begin
                route[s] <= wmask;
            end
        end
    end

endmodule

// File: rtl/pic_prio_pick.sv
// Module: pic_prio_pick
// Fixed-priority selector: reports whether any input is set and the
// smallest index that is set. Purely combinational.
module pic_prio_pick #(
    parameter int N_SRC = 64,
    parameter int IDX_W = 6
) (
    input  logic [N_SRC-1:0] elig,
    output logic             found,
    output logic [IDX_W-1:0] idx
);

    // Scan from the top so the lowest set index is the last one kept.
    always_comb begin
        found = |elig;
        idx   = '0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (elig[i]) idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/prio_irq_ctrl.sv
// Module: prio_irq_ctrl (top)
// Interrupt controller with mask and software-trigger bits per source, a
// routing mask per source, a banked event word per processor that returns
// and masks the lowest-numbered deliverable source, and a request line per
// processor. Register port: word addressed, always ready, read data one
// cycle after the accepted request.
// Assumes: 2 <= N_CPU <= 32, N_SRC <= 256, single access per cycle.
module prio_irq_ctrl
    import prio_irq_pkg::*;
#(
    parameter int N_SRC = 64,
    parameter int N_CPU = 2,
    parameter int CPU_W = (N_CPU > 1) ? $clog2(N_CPU) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  irq_in,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [CPU_W-1:0]  bus_cpu,
    input  logic [9:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic              bus_ready,
    output logic              bus_rvalid,
    output logic [31:0]       bus_rdata,
    output logic [N_CPU-1:0]  cpu_irq
);

    localparam int N_WORD = (N_SRC + 31) / 32;
    localparam int IDX_W  = (N_SRC > 1) ? $clog2(N_SRC) : 1;

    // Decode fields.
    logic [1:0] region;
    logic [3:0] grp;
    logic [3:0] ofs;
    logic       wr_acc, rd_acc;
    logic       word_ok, route_ok, cpu_ok;

    // Register state.
    logic [N_SRC-1:0]            mask_q;
    logic [N_SRC-1:0]            trig_q;
    logic [N_SRC-1:0][N_CPU-1:0] route_q;

    // Selection results per processor.
    logic [N_CPU-1:0][N_SRC-1:0] elig;
    logic [N_CPU-1:0]            pick_found;
    logic [N_CPU-1:0][IDX_W-1:0] pick_idx;

    // Event path.
    logic             ev_rd;
    logic             sel_found;
    logic [IDX_W-1:0] sel_idx;
    logic [N_SRC-1:0] ack_set;
    logic [31:0]      rd_value;

    // Padded copies for word-wide readback.
    logic [N_WORD*32-1:0] mask_pad;
    logic [N_WORD*32-1:0] trig_pad;

    assign bus_ready = 1'b1;

    // Split the address and qualify the access.
    always_comb begin
        region   = bus_addr[9:8];
        grp      = bus_addr[7:4];
        ofs      = bus_addr[3:0];
        wr_acc   = bus_valid && bus_write;
        rd_acc   = bus_valid && !bus_write;
        word_ok  = int'(ofs) < N_WORD;
        route_ok = int'(bus_addr[7:0]) < N_SRC;
        cpu_ok   = int'(bus_cpu) < N_CPU;
    end

    // Mask bank: set by writes and by acknowledges, reset to all masked.
    pic_bitvec_bank #(
        .N_SRC     (N_SRC),
        .RESET_VAL (1'b1)
    ) mask_bank_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_we   (wr_acc && region == REGION_LOW && grp == GRP_MASK_SET && word_ok),
        .clr_we   (wr_acc && region == REGION_LOW && grp == GRP_MASK_CLR && word_ok),
        .word_idx (ofs),
        .wdata    (bus_wdata),
        .auto_set (ack_set),
        .state    (mask_q)
    );

    // Software trigger bank: reset to all clear, no automatic set.
    pic_bitvec_bank #(
        .N_SRC     (N_SRC),
        .RESET_VAL (1'b0)
    ) trig_bank_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_we   (wr_acc && region == REGION_LOW && grp == GRP_TRIG_SET && word_ok),
        .clr_we   (wr_acc && region == REGION_LOW && grp == GRP_TRIG_CLR && word_ok),
        .word_idx (ofs),
        .wdata    (bus_wdata),
        .auto_set ({N_SRC{1'b0}}),
        .state    (trig_q)
    );

    // Routing masks.
    pic_route_bank #(
        .N_SRC (N_SRC),
        .N_CPU (N_CPU)
    ) route_bank_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (wr_acc && region == REGION_ROUTE && route_ok),
        .src_idx (bus_addr[7:0]),
        .wmask   (bus_wdata[N_CPU-1:0]),
        .route   (route_q)
    );

    // One eligibility vector and one selector per processor.
    for (genvar c = 0; c < N_CPU; c++) begin : g_cpu
        // Pending, unmasked and routed to processor c.
        always_comb begin
            for (int i = 0; i < N_SRC; i++) begin
                elig[c][i] = (irq_in[i] || trig_q[i]) && !mask_q[i] && route_q[i][c];
            end
        end

        pic_prio_pick #(
            .N_SRC (N_SRC),
            .IDX_W (IDX_W)
        ) pick_i (
            .elig  (elig[c]),
            .found (pick_found[c]),
            .idx   (pick_idx[c])
        );
    end

    assign cpu_irq = pick_found;

    // Choose the accessing processor's selection and form the acknowledge.
    always_comb begin
        ev_rd     = rd_acc && region == REGION_LOW && grp == GRP_CTRL &&
                    ofs == OFS_EVENT && cpu_ok;
        sel_found = 1'b0;
        sel_idx   = '0;
        for (int c = 0; c < N_CPU; c++) begin
            if (int'(bus_cpu) == c) begin
                sel_found = pick_found[c];
                sel_idx   = pick_idx[c];
            end
        end
        ack_set = '0;
        if (ev_rd && sel_found) ack_set[sel_idx] = 1'b1;
    end

    // Zero-extend the state vectors to whole words.
    always_comb begin
        mask_pad = '0;
        trig_pad = '0;
        mask_pad[N_SRC-1:0] = mask_q;
        trig_pad[N_SRC-1:0] = trig_q;
    end

    // Read data multiplexer.
    always_comb begin
        rd_value = '0;
        if (region == REGION_ROUTE) begin
            for (int s = 0; s < N_SRC; s++) begin
                if (int'(bus_addr[7:0]) == s) rd_value = 32'(route_q[s]);
            end
        end else if (region == REGION_LOW) begin
            case (grp)
                GRP_CTRL: begin
                    if (ofs == OFS_WHOAMI) begin
                        rd_value = 32'(bus_cpu);
                    end else if (ofs == OFS_EVENT && sel_found) begin
                        rd_value = make_event(16'(sel_idx));
                    end
                end
                GRP_MASK_SET, GRP_MASK_CLR: begin
                    for (int w = 0; w < N_WORD; w++) begin
                        if (int'(ofs) == w) rd_value = mask_pad[w*32 +: 32];
                    end
                end
                GRP_TRIG_SET, GRP_TRIG_CLR: begin
                    for (int w = 0; w < N_WORD; w++) begin
                        if (int'(ofs) == w) rd_value = trig_pad[w*32 +: 32];
                    end
                end
                default: rd_value = '0;
            endcase
        end
    end

    // Read response register: data and valid one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rvalid <= 1'b0;
            bus_rdata  <= '0;
        end else begin
            bus_rvalid <= rd_acc;
            bus_rdata  <= rd_acc ? rd_value : 32'h0;
        end
    end

endmodule

// File: rtl/prio_irq_ctrl_chk.sv
// Module: prio_irq_ctrl_chk
// Checker bound to prio_irq_ctrl: relates event reads, the read response,
// the request outputs and the mask state over time.
module prio_irq_ctrl_chk #(
    parameter int N_SRC = 64,
    parameter int N_CPU = 2,
    parameter int CPU_W = 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_valid,
    input logic             bus_write,
    input logic [CPU_W-1:0] bus_cpu,
    input logic [9:0]       bus_addr,
    input logic             bus_rvalid,
    input logic [31:0]      bus_rdata,
    input logic [N_CPU-1:0] cpu_irq,
    input logic [N_SRC-1:0] mask_q
);

    localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;

    logic ev_rd_q;
    logic irq_sel_q;
    logic rd_q;

    // Remember whether the last cycle held an event read and its request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ev_rd_q   <= 1'b0;
            irq_sel_q <= 1'b0;
            rd_q      <= 1'b0;
        end else begin
            rd_q      <= bus_valid && !bus_write;
            ev_rd_q   <= bus_valid && !bus_write && bus_addr == 10'h001 &&
                         int'(bus_cpu) < N_CPU;
            irq_sel_q <= (int'(bus_cpu) < N_CPU) ? cpu_irq[bus_cpu] : 1'b0;
        end
    end

    // R10: response valid follows exactly the accepted reads.
    p_rvalid_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rvalid == rd_q);

    // R4: a returned source is masked once the response appears.
    p_ack_masks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_rd_q && bus_rdata != 32'h0) |-> mask_q[bus_rdata[IDX_W-1:0]]);

    // R5: an empty event word only when the processor had no request.
    p_empty_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_rd_q && bus_rdata == 32'h0) |-> !irq_sel_q);

    // R1: a raised request always yields a non-empty event word.
    p_req_gives_event_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_rd_q && irq_sel_q) |-> bus_rdata != 32'h0);

    // R3: a non-empty event word carries the hardware type and a valid number.
    p_event_fmt_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_rd_q && bus_rdata != 32'h0) |->
            (bus_rdata[31:16] == 16'h0001 && int'(bus_rdata[15:0]) < N_SRC));

endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(
    .N_SRC (N_SRC),
    .N_CPU (N_CPU),
    .CPU_W (CPU_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_valid  (bus_valid),
    .bus_write  (bus_write),
    .bus_cpu    (bus_cpu),
    .bus_addr   (bus_addr),
    .bus_rvalid (bus_rvalid),
    .bus_rdata  (bus_rdata),
    .cpu_irq    (cpu_irq),
    .mask_q     (mask_q)
);

// File: tb/prio_irq_ctrl_tb_top.sv
// Bench for prio_irq_ctrl: directed corner cases, then seeded random
// operations compared against a bench model of the requirements.
module prio_irq_ctrl_tb_top;

    localparam int N_SRC = 64;
    localparam int N_CPU = 2;
    localparam int N_WORD = N_SRC / 32;

    localparam logic [9:0] A_WHOAMI = 10'h000;
    localparam logic [9:0] A_EVENT  = 10'h001;
    localparam logic [9:0] A_MSET   = 10'h010;
    localparam logic [9:0] A_MCLR   = 10'h020;
    localparam logic [9:0] A_TSET   = 10'h030;
    localparam logic [9:0] A_TCLR   = 10'h040;
    localparam logic [9:0] A_ROUTE  = 10'h100;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [N_SRC-1:0] irq_in = '0;
    logic             bus_valid = 1'b0;
    logic             bus_write = 1'b0;
    logic [0:0]       bus_cpu = '0;
    logic [9:0]       bus_addr = '0;
    logic [31:0]      bus_wdata = '0;
    logic             bus_ready;
    logic             bus_rvalid;
    logic [31:0]      bus_rdata;
    logic [N_CPU-1:0] cpu_irq;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    // Bench model.
    logic [N_SRC-1:0] m_mask;
    logic [N_SRC-1:0] m_trig;
    logic [N_CPU-1:0] m_route [N_SRC];

    always #10 clk = ~clk;

    prio_irq_ctrl #(.N_SRC(N_SRC), .N_CPU(N_CPU)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .irq_in     (irq_in),
        .bus_valid  (bus_valid),
        .bus_write  (bus_write),
        .bus_cpu    (bus_cpu),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_ready  (bus_ready),
        .bus_rvalid (bus_rvalid),
        .bus_rdata  (bus_rdata),
        .cpu_irq    (cpu_irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic bit deliverable(input int s, input int c);
        return (irq_in[s] || m_trig[s]) && !m_mask[s] && m_route[s][c];
    endfunction

    function automatic logic [N_CPU-1:0] exp_irq();
        logic [N_CPU-1:0] r = '0;
        for (int c = 0; c < N_CPU; c++)
            for (int s = 0; s < N_SRC; s++)
                if (deliverable(s, c)) r[c] = 1'b1;
        return r;
    endfunction

    task automatic bus_wr(input int cpu, input logic [9:0] addr, input logic [31:0] data);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_cpu = 1'(cpu);
        bus_addr = addr; bus_wdata = data;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
        // Model update.
        if (addr[9:8] == 2'b01 && int'(addr[7:0]) < N_SRC) begin
            m_route[addr[7:0]] = data[N_CPU-1:0];
        end else if (addr[9:8] == 2'b00 && int'(addr[3:0]) < N_WORD) begin
            for (int b = 0; b < 32; b++) begin
                int s = int'(addr[3:0]) * 32 + b;
                if (data[b]) begin
                    case (addr[7:4])
                        4'h1: m_mask[s] = 1'b1;
                        4'h2: m_mask[s] = 1'b0;
                        4'h3: m_trig[s] = 1'b1;
                        4'h4: m_trig[s] = 1'b0;
                        default: ;
                    endcase
                end
            end
        end
    endtask

    task automatic bus_rd(input int cpu, input logic [9:0] addr, output logic [31:0] data,
                          input string req);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_cpu = 1'(cpu); bus_addr = addr;
        @(negedge clk);
        bus_valid = 1'b0;
        check({req, " R10 rvalid"}, 32'(bus_rvalid), 32'd1);
        data = bus_rdata;
    endtask

    // Event read checked against the model; applies the acknowledge to the model.
    task automatic ev_check(input int cpu, input string req);
        logic [31:0] got, exp;
        int win = -1;
        for (int s = N_SRC - 1; s >= 0; s--) if (deliverable(s, cpu)) win = s;
        exp = (win < 0) ? 32'h0 : {8'h00, 8'h01, 16'(win)};
        bus_rd(cpu, A_EVENT, got, req);
        if (win >= 0) m_mask[win] = 1'b1;
        check(req, got, exp);
    endtask

    task automatic irq_check(input string req);
        check(req, 32'(cpu_irq), 32'(exp_irq()));
    endtask

    task automatic word_check(input string req);
        logic [31:0] got;
        for (int w = 0; w < N_WORD; w++) begin
            bus_rd(0, A_MSET + 10'(w), got, req);
            check({req, " mask word"}, got, m_mask[w*32 +: 32]);
            bus_rd(1, A_TCLR + 10'(w), got, req);
            check({req, " trigger word"}, got, m_trig[w*32 +: 32]);
        end
    endtask

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] got;
        void'($urandom(32'd20240611));
        m_mask = '1; m_trig = '0;
        for (int s = 0; s < N_SRC; s++) m_route[s] = N_CPU'(1);

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // Reset image (R7).
        @(negedge clk);
        check("R7 requests after reset", 32'(cpu_irq), 32'h0);
        check("R10 ready", 32'(bus_ready), 32'd1);
        word_check("R7 reset state");
        bus_rd(0, A_ROUTE + 10'd0, got, "R7");  check("R7 route 0", got, 32'h1);
        bus_rd(1, A_ROUTE + 10'd63, got, "R7"); check("R7 route 63", got, 32'h1);
        ev_check(0, "R5 empty after reset");

        // Processor index readback (R9).
        bus_rd(0, A_WHOAMI, got, "R9"); check("R9 cpu0", got, 32'd0);
        bus_rd(1, A_WHOAMI, got, "R9"); check("R9 cpu1", got, 32'd1);

        // Masked line gives nothing (R1).
        irq_in[5] = 1'b1; irq_in[40] = 1'b1;
        @(negedge clk);
        irq_check("R1 masked lines");
        ev_check(0, "R1 masked event");

        // Trigger on 3, unmask 3, 5 and 40 (R6 with 0 bits idle).
        bus_wr(0, A_TSET, 32'h0000_0008);
        bus_wr(0, A_MCLR, 32'h0000_0028);
        bus_wr(1, A_MCLR + 10'd1, 32'h0000_0100);
        word_check("R6 bit indexing");
        check("R6 mask word0 literal", m_mask[31:0], 32'hFFFF_FFD7);
        irq_check("R1 unmasked");
        ev_check(1, "R8 cpu1 not routed");
        ev_check(0, "R2 first 3");
        ev_check(0, "R4 then 5");
        ev_check(0, "R4 then 40");
        ev_check(0, "R5 empty after acks");
        irq_check("R4 all acked");

        // Route 10 to processor 1 only (R8).
        bus_wr(0, A_ROUTE + 10'd10, 32'h2);
        bus_rd(0, A_ROUTE + 10'd10, got, "R8"); check("R8 route readback", got, 32'h2);
        bus_wr(0, A_TSET, 32'h0000_0400);
        bus_wr(0, A_MCLR, 32'h0000_0400);
        irq_check("R8 routed request");
        ev_check(0, "R8 cpu0 ignores 10");
        ev_check(1, "R8 cpu1 takes 10");
        bus_wr(0, A_TCLR, 32'h0000_0400);

        // Random phase.
        for (int it = 0; it < 1500; it++) begin
            int op = $urandom_range(0, 7);
            int w  = $urandom_range(0, N_WORD - 1);
            logic [31:0] d = $urandom & $urandom;
            @(negedge clk);
            irq_in = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
            @(negedge clk);
            irq_check("R1 random lines");
            case (op)
                0: bus_wr($urandom_range(0, 1), A_MSET + 10'(w), d);
                1: bus_wr($urandom_range(0, 1), A_MCLR + 10'(w), d | $urandom);
                2: bus_wr($urandom_range(0, 1), A_TSET + 10'(w), d);
                3: bus_wr($urandom_range(0, 1), A_TCLR + 10'(w), d);
                4: bus_wr(0, A_ROUTE + 10'($urandom_range(0, N_SRC - 1)),
                          32'($urandom_range(0, 3)));
                default: ev_check($urandom_range(0, 1), "R2 random event");
            endcase
            irq_check("R1 after op");
            if (it % 100 == 0) word_check("R6 random readback");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule